// File: doc/BRIEF.md
# Speculative Predicate Prediction Unit

This unit holds the predicate bits of a pipelined processing element whose instructions issue when their trigger conditions match the predicates. An instruction that computes a predicate value in the ALU learns that value several stages after it issues. If nothing were done, the scheduler would stall until then. Instead, the unit predicts the value when such an instruction issues and writes the guess into the visible predicate state at once. Triggering can then continue. Each predicate has its own saturating confidence counter, selected by predicate number.

Only one prediction is outstanding at a time. When a prediction is made, the unit stores a fallback copy of the predicate state. When the ALU result arrives, the unit compares it with the guess. On a match, the speculation ends. On a mismatch, the unit raises a one-cycle flush and restores the fallback copy, with the resolved bit written in. While a guess is outstanding, the unit raises a speculating flag. The scheduler uses this flag to hold back instructions with early side effects, such as input queue dequeues.

Every issued instruction also carries set and clear masks that force predicate bits. The unit applies these masks in the issue cycle.

Top module: `pred_spec_unit`

## Requirements
- R1: After a synchronous reset, `pred_state` is 0 and `speculating` and `flush` are 0. Every counter holds 1 (weakly false), so the first prediction for any predicate is 0.
- R2: An accepted issue with `issue_dst_is_pred` = 1 writes a guess into bit `issue_dst_idx` of `pred_state` one cycle later. The guess is the MSB of that predicate's counter, read before any same-cycle update. `speculating` reads 1 from that cycle on.
- R3: An accepted issue first clears the bits in `issue_clr_mask` and then sets the bits in `issue_set_mask`. A set bit therefore wins over a clear bit. The result is visible one cycle later. An issue with `issue_dst_is_pred` = 0 is accepted unless a mispredict resolves in the same cycle.
- R4: A predicate-destination issue is ignored, including its masks, in either of two cases. The first is that `speculating` is 1 and no matching resolve arrives in the same cycle. The second is that a mispredict resolves in the same cycle.
- R5: A resolve whose value equals the guess confirms the guess. `speculating` falls the next cycle unless a new prediction starts in the same cycle. `flush` stays 0 and the guessed bit is kept.
- R6: A resolve whose value differs from the guess drives `flush` to 1 for exactly one cycle. In that same following cycle, `speculating` falls. `pred_state` becomes the fallback copy, which is the state saved at prediction after that instruction's own masks, with bit `issue_dst_idx` replaced by the resolved value. Issues made during the speculation are discarded.
- R7: A matching resolve and a predicate-destination issue in the same cycle start a new prediction. `speculating` stays 1.
- R8: A counter changes only at a resolve. It increments on a resolved 1 and decrements on a resolved 0, and it saturates at 0 and 3. A counter value of 2 or 3 predicts 1.
- R9: A resolve while `speculating` is 0 has no effect on `pred_state`, `flush` or the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_dst_is_pred | input | 1 | The issuing instruction writes a predicate from the ALU |
| issue_dst_idx | input | 3 | Index of that destination predicate |
| issue_set_mask | input | 8 | Predicate bits forced to 1 on issue |
| issue_clr_mask | input | 8 | Predicate bits forced to 0 on issue |
| resolve_valid | input | 1 | The ALU result for the outstanding prediction is present |
| resolve_value | input | 1 | Resolved predicate value |
| pred_state | output | 8 | Visible (possibly speculative) predicate state |
| speculating | output | 1 | A prediction is outstanding; hold back side effects |
| flush | output | 1 | One-cycle pulse after a misprediction |

## Verification
Two corners are hard to reach from the ports. The first is a confirmed resolve in the same cycle as a new prediction, especially when both target the same predicate. There the new guess must use the counter value from before the update. The second is a mispredict that arrives after younger mask-only issues have changed the visible state. Directed sequences build each case on purpose. They first drive one counter into the predicts-1 range and then to saturation. They then chain back-to-back confirm-and-predict cycles and interleave mask writes before a wrong guess. A long random phase follows, with resolves made likely only while a guess is outstanding. A behavioural model checks every cycle.

// File: rtl/pspu_pkg.sv
package pspu_pkg;
  typedef enum logic {
    SP_IDLE = 1'b0,
    SP_WAIT = 1'b1
  } spec_state_e;
endpackage

// File: rtl/pspu_counter_bank.sv
module pspu_counter_bank #(
  parameter int NPRED = 8,
  parameter int CTR_W = 2,
  localparam int IDX_W = $clog2(NPRED)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          upd_en,
  input  logic [IDX_W-1:0]              upd_idx,
  input  logic                          upd_taken,
  output logic [NPRED-1:0][CTR_W-1:0]   ctr_q
);
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  for (genvar g = 0; g < NPRED; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst) begin
        ctr_q[g] <= CTR_INIT;
      end else if (upd_en && upd_idx == IDX_W'(g)) begin
        if (upd_taken && ctr_q[g] != CTR_MAX)
          ctr_q[g] <= ctr_q[g] + 1'b1;
        else if (!upd_taken && ctr_q[g] != '0)
          ctr_q[g] <= ctr_q[g] - 1'b1;
      end
    end
  end

  // R8: counters move only on a resolve
  a_r8_ctr_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(ctr_q));
endmodule

// File: rtl/pspu_state_regs.sv
module pspu_state_regs #(
  parameter int NPRED = 8,
  localparam int IDX_W = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vis_ld,
  input  logic [NPRED-1:0] vis_d,
  input  logic             ckpt_ld,
  input  logic [NPRED-1:0] ckpt_d,
  input  logic             restore,
  input  logic [IDX_W-1:0] restore_idx,
  input  logic             restore_val,
  output logic [NPRED-1:0] vis_q
);
  logic [NPRED-1:0] ckpt_q;
  logic [NPRED-1:0] restored;

  always_comb begin
    restored = ckpt_q;
    restored[restore_idx] = restore_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q  <= '0;
      ckpt_q <= '0;
    end else begin
      if (restore)     vis_q <= restored;
      else if (vis_ld) vis_q <= vis_d;
      if (ckpt_ld)     ckpt_q <= ckpt_d;
    end
  end

  // R3/R9: visible state is untouched without a load or a restore
  a_r9_vis_hold: assert property (@(posedge clk) disable iff (rst)
    (!vis_ld && !restore) |=> $stable(vis_q));
endmodule

// File: rtl/pred_spec_unit.sv
module pred_spec_unit #(
  parameter int NPRED = 8,
  parameter int CTR_W = 2,
  localparam int IDX_W = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic             issue_dst_is_pred,
  input  logic [IDX_W-1:0] issue_dst_idx,
  input  logic [NPRED-1:0] issue_set_mask,
  input  logic [NPRED-1:0] issue_clr_mask,
  input  logic             resolve_valid,
  input  logic             resolve_value,
  output logic [NPRED-1:0] pred_state,
  output logic             speculating,
  output logic             flush
);
  import pspu_pkg::*;

  spec_state_e           st_q;
  logic                  guess_q;
  logic [IDX_W-1:0]      sidx_q;
  logic                  flush_q;
  logic [NPRED-1:0][CTR_W-1:0] ctr;

  logic resolve_hit, hit_ok, hit_bad, can_pred, acc_pred, acc_plain, guess_now;
  logic [NPRED-1:0] masked, with_guess;

  assign resolve_hit = resolve_valid && (st_q == SP_WAIT);
  assign hit_ok      = resolve_hit && (resolve_value == guess_q);
  assign hit_bad     = resolve_hit && (resolve_value != guess_q);
  assign can_pred    = (st_q == SP_IDLE) || hit_ok;
  assign acc_pred    = issue_valid && issue_dst_is_pred && can_pred;
  assign acc_plain   = issue_valid && !issue_dst_is_pred && !hit_bad;
  assign guess_now   = ctr[issue_dst_idx][CTR_W-1];

  always_comb begin
    masked = (pred_state & ~issue_clr_mask) | issue_set_mask;
    with_guess = masked;
    with_guess[issue_dst_idx] = guess_now;
  end

  pspu_counter_bank #(.NPRED(NPRED), .CTR_W(CTR_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (resolve_hit),
    .upd_idx   (sidx_q),
    .upd_taken (resolve_value),
    .ctr_q     (ctr)
  );

  pspu_state_regs #(.NPRED(NPRED)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .vis_ld      (acc_pred || acc_plain),
    .vis_d       (acc_pred ? with_guess : masked),
    .ckpt_ld     (acc_pred),
    .ckpt_d      (masked),
    .restore     (hit_bad),
    .restore_idx (sidx_q),
    .restore_val (resolve_value),
    .vis_q       (pred_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SP_IDLE;
      guess_q <= 1'b0;
      sidx_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= hit_bad;
      if (hit_bad) begin
        st_q <= SP_IDLE;
      end else if (acc_pred) begin
        st_q    <= SP_WAIT;
        guess_q <= guess_now;
        sidx_q  <= issue_dst_idx;
      end else if (hit_ok) begin
        st_q <= SP_IDLE;
      end
    end
  end

  assign speculating = (st_q == SP_WAIT);
  assign flush       = flush_q;

  // R6: flush lasts one cycle and ends the speculation
  a_r6_flush_one_cycle: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);
  a_r6_flush_ends_spec: assert property (@(posedge clk) disable iff (rst)
    flush |-> !speculating);
  // R2: speculation begins only from a predicate-destination issue
  a_r2_spec_start: assert property (@(posedge clk) disable iff (rst)
    $rose(speculating) |-> $past(issue_valid && issue_dst_is_pred));
  // R4: without a resolve the speculation persists
  a_r4_spec_held: assert property (@(posedge clk) disable iff (rst)
    (speculating && !resolve_valid) |=> speculating);
endmodule

// File: tb/sim_pred_spec_unit.sv
`timescale 1ns/1ps
module sim_pred_spec_unit;
  logic clk = 1'b0;
  logic rst;
  logic issue_valid, issue_dst_is_pred, resolve_valid, resolve_value;
  logic [2:0] issue_dst_idx;
  logic [7:0] issue_set_mask, issue_clr_mask;
  logic [7:0] pred_state;
  logic speculating, flush;

  always #4 clk = ~clk;

  pred_spec_unit u0 (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_dst_is_pred(issue_dst_is_pred),
    .issue_dst_idx(issue_dst_idx), .issue_set_mask(issue_set_mask),
    .issue_clr_mask(issue_clr_mask), .resolve_valid(resolve_valid),
    .resolve_value(resolve_value), .pred_state(pred_state),
    .speculating(speculating), .flush(flush)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference
  bit [7:0] m_vis, m_ckpt;
  int m_ctr[8];
  bit m_spec, m_guess, m_flush;
  int m_sidx;

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "pred_state", pred_state, m_vis);
    check(tag, "speculating", speculating, m_spec);
    check(tag, "flush", flush, m_flush);
  endtask

  task automatic model_reset();
    m_vis = 0; m_ckpt = 0; m_spec = 0; m_guess = 0; m_flush = 0; m_sidx = 0;
    for (int i = 0; i < 8; i++) m_ctr[i] = 1;
  endtask

  // drive one cycle, advance model, compare after the edge
  task automatic step(string tag, bit iv, bit ip, int idx, bit [7:0] sm,
                      bit [7:0] cm, bit rv, bit rval);
    bit hit, ok, miss, take_pred, take_plain, g;
    bit [7:0] mk;
    issue_valid = iv; issue_dst_is_pred = ip; issue_dst_idx = 3'(idx);
    issue_set_mask = sm; issue_clr_mask = cm;
    resolve_valid = rv; resolve_value = rval;
    hit = rv && m_spec;
    ok = hit && (rval == m_guess);
    miss = hit && !ok;
    take_pred = iv && ip && (!m_spec || ok);
    take_plain = iv && !ip && !miss;
    g = (m_ctr[idx] >= 2);
    mk = (m_vis & ~cm) | sm;
    if (hit) begin
      if (rval) begin if (m_ctr[m_sidx] < 3) m_ctr[m_sidx]++; end
      else      begin if (m_ctr[m_sidx] > 0) m_ctr[m_sidx]--; end
    end
    m_flush = miss;
    if (miss) begin
      m_vis = m_ckpt;
      m_vis[m_sidx] = rval;
      m_spec = 0;
    end else if (take_pred) begin
      m_ckpt = mk;
      m_vis = mk;
      m_vis[idx] = g;
      m_spec = 1;
      m_guess = g;
      m_sidx = idx;
    end else begin
      if (take_plain) m_vis = mk;
      if (ok) m_spec = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 8'h00, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    issue_valid = 0; issue_dst_is_pred = 0; issue_dst_idx = 0;
    issue_set_mask = 0; issue_clr_mask = 0; resolve_valid = 0; resolve_value = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1");
    // R1: first guess for a fresh predicate is 0
    step("R1", 1, 1, 1, 8'h02, 8'h00, 0, 0);
    check("R1", "fresh guess bit1", pred_state[1], 0);
    step("R5", 0, 0, 0, 8'h00, 8'h00, 1, 0);
    // R3: masks, set wins over clear
    step("R3", 1, 0, 0, 8'h0F, 8'h00, 0, 0);
    step("R3", 1, 0, 0, 8'h30, 8'h33, 0, 0);
    check("R3", "set over clear", pred_state, 8'h3C);
    // R2: prediction on predicate 5
    step("R2", 1, 1, 5, 8'h00, 8'h00, 0, 0);
    check("R2", "speculating", speculating, 1);
    // R4: nested prediction ignored, its masks too
    step("R4", 1, 1, 6, 8'h80, 8'h00, 0, 0);
    check("R4", "nested masks ignored", pred_state[7], 0);
    // R5: confirm
    step("R5", 0, 0, 0, 8'h00, 8'h00, 1, 0);
    check("R5", "spec falls", speculating, 0);
    // R9: stray resolve
    step("R9", 0, 0, 0, 8'h00, 8'h00, 1, 1);
    check("R9", "no flush", flush, 0);
    // R6: mispredict with younger mask issue discarded
    step("R6", 1, 1, 5, 8'h01, 8'h00, 0, 0);
    step("R6", 1, 0, 0, 8'h40, 8'h00, 0, 0);
    step("R6", 1, 0, 0, 8'h00, 8'h04, 1, 1);
    check("R6", "flush", flush, 1);
    check("R6", "bit5 resolved", pred_state[5], 1);
    check("R6", "young mask gone", pred_state[6], 0);
    idle("R6");
    check("R6", "flush one cycle", flush, 0);
    // R8: train predicate 5 up to predicts-1 and saturate
    step("R8", 1, 1, 5, 8'h00, 8'h00, 0, 0);
    step("R8", 0, 0, 0, 8'h00, 8'h00, 1, 1);
    step("R8", 1, 1, 5, 8'h00, 8'h00, 0, 0);
    check("R8", "guess 1 at ctr 2", pred_state[5], 1);
    // R7: confirm and re-predict same predicate in one cycle
    step("R7", 1, 1, 5, 8'h00, 8'h00, 1, 1);
    check("R7", "still speculating", speculating, 1);
    step("R7", 1, 1, 3, 8'h00, 8'h00, 1, 1);
    step("R8", 0, 0, 0, 8'h00, 8'h00, 1, 0);
    step("R8", 1, 1, 5, 8'h00, 8'h00, 0, 0);
    check("R8", "saturated predicts 1", pred_state[5], 1);
    step("R8", 0, 0, 0, 8'h00, 8'h00, 1, 0);
    step("R8", 1, 1, 5, 8'h00, 8'h20, 0, 0);
    check("R8", "ctr 2 predicts 1", pred_state[5], 1);
    step("R8", 0, 0, 0, 8'h00, 8'h00, 1, 1);
    // random phase, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      bit iv, ip, rv;
      iv = ($urandom_range(0, 2) != 0);
      ip = $urandom_range(0, 1);
      rv = m_spec ? ($urandom_range(0, 2) != 0) : ($urandom_range(0, 7) == 0);
      step("R8", iv, ip, $urandom_range(0, 7), 8'($urandom_range(0, 255)),
           8'($urandom_range(0, 255)), rv, $urandom_range(0, 1));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule